// File: doc/BRIEF.md
# Fixed-Latency Shared Store Arbiter

This block is a small word-addressed store that three pipeline clients share: a memory stage (port 0), an instruction fetch stage (port 1) and a first-level cache (port 2). A client that wants to write raises its valid bit and keeps its address and data steady. It keeps the request up every cycle until the block answers OK. Every write costs a fixed number of wait cycles, which is set by a parameter.

Arbitration works as a lock. The first client to reach an idle block takes ownership and holds it until its own write commits. A countdown loaded with the configured delay runs while the owner keeps its request up. Every other client is told to wait. When the countdown is exhausted, the word is stored, the owner is told OK and the lock is released. A registered debug port shows one full line of four words, for checking and bring-up.

Top module: `lock_arb_store`

## Requirements
- R1: After a synchronous reset, every port reports NONE, the lock is free and every stored word reads back as zero through the debug port.
- R2: Address bits [1:0] pick the word within a line and the upper bits pick the line. Word k of a line appears in bits [32k+31:32k] of `dbg_words` (for 32-bit words). `dbg_words` shows the selected line as it stood before the most recent clock edge.
- R3: With delay D, a client that takes a free block and holds its request receives D WAIT responses followed by OK on its (D+1)th request cycle. Each response is visible after the clock edge that sampled the request.
- R4: The stored word is unchanged until the clock edge of the completing cycle, so the debug view shows the old contents through every WAIT cycle.
- R5: A client that does not hold the lock receives WAIT. Its request changes neither the countdown nor the stored contents.
- R6: When several clients request in the same cycle while the block is free, the lock goes to the memory stage first, then the fetch stage, then the cache.
- R7: The lock is released on the completing cycle, and no other client is granted in that cycle. A waiting client takes the lock in the following cycle and then needs its own full D+1 request cycles.
- R8: A port with no active request reports NONE. If the owner drops its request, it keeps the lock and the countdown stays frozen until the request returns.
- R9: Response codes are 2 bits per port: NONE = 0, WAIT = 1, OK = 2. Port i uses bits [2i+1:2i] of `rsp`.
- R10: With delay 0, a client that finds the block free commits and receives OK in its first request cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 3 | Write request per client (0 memory, 1 fetch, 2 cache) |
| req_addr | input | 3 x ADDR_W | Word address per client |
| req_data | input | 3 x WORD_W | Write data per client |
| rsp | output | 3 x 2 | Registered response per client |
| dbg_line | input | LINE_W | Line selected for the debug view |
| dbg_words | output | 4 x WORD_W | Registered contents of the selected line |

## Verification
A single client holding its request checks the D WAIT, then OK, count, and shows that the array keeps its old value until the commit edge. Two clients with staggered arrival confirm that the lock is held by whoever came first and that the loser starts a fresh countdown only after release. All three clients arriving together separate fixed priority from any other order. In a pause pattern the owner drops its request while another client pokes at the block; an OK arriving early there would reveal a countdown that leaked or was stolen. A second instance with zero delay exercises immediate commit, and shows that no client is granted in the same cycle as a commit.

// File: rtl/lock_arb_pkg.sv
package lock_arb_pkg;
  localparam int unsigned NUM_REQ    = 3;
  localparam int unsigned LINE_WORDS = 4;

  typedef enum logic [1:0] {
    OWN_MEM   = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_L1    = 2'd2,
    OWN_IDLE  = 2'd3
  } owner_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_WAIT = 2'd1,
    RSP_OK   = 2'd2
  } rsp_e;
endpackage

// File: rtl/lock_arb_ctrl.sv
module lock_arb_ctrl
  import lock_arb_pkg::*;
#(
  parameter int unsigned DELAY = 3,
  parameter int unsigned CNT_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_REQ-1:0]          req_valid,
  output owner_e                      owner_q,
  output logic [CNT_W-1:0]            cnt_q,
  output logic                        commit_en,
  output logic [1:0]                  commit_idx,
  output logic [NUM_REQ-1:0][1:0]     rsp_q
);

  owner_e               pick;
  owner_e               eff_owner;
  owner_e               owner_d;
  logic [CNT_W-1:0]     eff_cnt;
  logic [CNT_W-1:0]     cnt_d;
  logic [NUM_REQ-1:0]   owner_hit;
  logic                 active;
  logic [NUM_REQ-1:0][1:0] rsp_d;

  // fixed priority: lowest index wins, scanned from the top down
  always_comb begin
    pick = OWN_IDLE;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req_valid[i]) pick = owner_e'(2'(i));
    end
  end

  always_comb begin
    eff_owner = (owner_q == OWN_IDLE) ? pick : owner_q;
    eff_cnt   = (owner_q == OWN_IDLE) ? CNT_W'(DELAY) : cnt_q;
    for (int i = 0; i < NUM_REQ; i++) begin
      owner_hit[i] = (eff_owner == owner_e'(2'(i)));
    end
    active     = |(owner_hit & req_valid);
    commit_en  = active && (eff_cnt == '0);
    commit_idx = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (owner_hit[i]) commit_idx = 2'(i);
    end

    owner_d = owner_q;
    cnt_d   = cnt_q;
    if (active) begin
      if (eff_cnt == '0) begin
        owner_d = OWN_IDLE;
        cnt_d   = '0;
      end else begin
        owner_d = eff_owner;
        cnt_d   = eff_cnt - 1'b1;
      end
    end

    for (int i = 0; i < NUM_REQ; i++) begin
      if (!req_valid[i])                   rsp_d[i] = RSP_NONE;
      else if (owner_hit[i] && commit_en)  rsp_d[i] = RSP_OK;
      else                                 rsp_d[i] = RSP_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_IDLE;
      cnt_q   <= '0;
      rsp_q   <= '0;
    end else begin
      owner_q <= owner_d;
      cnt_q   <= cnt_d;
      rsp_q   <= rsp_d;
    end
  end

endmodule

// File: rtl/lock_arb_array.sv
module lock_arb_array
  import lock_arb_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LINE_W = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [WORD_W-1:0]                  wr_data,
  input  logic [LINE_W-1:0]                  rd_line,
  output logic [LINE_WORDS-1:0][WORD_W-1:0]  rd_words
);

  logic [LINE_W-1:0] wr_line;
  logic [1:0]        wr_word;

  assign wr_line = wr_addr[ADDR_W-1:2];
  assign wr_word = wr_addr[1:0];

  // one narrow memory per word lane, each with its own write enable
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] lane_mem [LINES];
    logic [WORD_W-1:0] lane_rd_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int l = 0; l < LINES; l++) lane_mem[l] <= '0;
        lane_rd_q <= '0;
      end else begin
        if (wr_en && (wr_word == 2'(w))) lane_mem[wr_line] <= wr_data;
        lane_rd_q <= lane_mem[rd_line];
      end
    end

    assign rd_words[w] = lane_rd_q;
  end

endmodule

// File: rtl/lock_arb_store.sv
module lock_arb_store
  import lock_arb_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DELAY  = 3,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned ADDR_W = LINE_W + 2,
  localparam int unsigned CNT_W  = $clog2(DELAY + 2)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [2:0]                   req_valid,
  input  logic [2:0][ADDR_W-1:0]       req_addr,
  input  logic [2:0][WORD_W-1:0]       req_data,
  output logic [2:0][1:0]              rsp,
  input  logic [LINE_W-1:0]            dbg_line,
  output logic [3:0][WORD_W-1:0]       dbg_words
);

  owner_e            owner_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              commit_en;
  logic [1:0]        commit_idx;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;

  lock_arb_ctrl #(
    .DELAY (DELAY),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .owner_q    (owner_q),
    .cnt_q      (cnt_q),
    .commit_en  (commit_en),
    .commit_idx (commit_idx),
    .rsp_q      (rsp)
  );

  always_comb begin
    wr_addr = req_addr[0];
    wr_data = req_data[0];
    for (int i = 1; i < NUM_REQ; i++) begin
      if (commit_idx == 2'(i)) begin
        wr_addr = req_addr[i];
        wr_data = req_data[i];
      end
    end
  end

  lock_arb_array #(
    .LINES  (LINES),
    .WORD_W (WORD_W),
    .LINE_W (LINE_W),
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (commit_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_line  (dbg_line),
    .rd_words (dbg_words)
  );

endmodule

// File: rtl/lock_arb_store_chk.sv
module lock_arb_store_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       req_valid,
  input logic [2:0][1:0]  rsp,
  input logic [1:0]       owner_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             commit_en
);

  logic [2:0] ok_vec;
  logic       owner_req;

  always_comb begin
    for (int i = 0; i < 3; i++) ok_vec[i] = (rsp[i] == 2'd2);
    owner_req = (owner_q != 2'd3) && req_valid[owner_q];
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (rsp == '0));

  // R3
  ok_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> ($countones(ok_vec) == 1));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (owner_q != 2'd3 && owner_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7
  idle_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> (owner_q == 2'd3));

  // R6
  grant_mem_first_chk: assert property (@(posedge clk) disable iff (rst)
    (owner_q == 2'd3 && req_valid[0] && !commit_en) |=> (owner_q == 2'd0));

  // R8
  paused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (owner_q != 2'd3 && !owner_req) |=> (owner_q == $past(owner_q) && cnt_q == $past(cnt_q)));

  for (genvar i = 0; i < 3; i++) begin : g_port
    // R5
    nonowner_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid[i] && owner_q != 2'd3 && owner_q != 2'(i)) |=> (rsp[i] == 2'd1));
  end

endmodule

bind lock_arb_store lock_arb_store_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .rsp       (rsp),
  .owner_q   (owner_q),
  .cnt_q     (cnt_q),
  .commit_en (commit_en)
);

// File: tb/lock_arb_store_bench.sv
`timescale 1ns/1ps
module lock_arb_store_bench;

  localparam int LINES = 8;
  localparam int WW    = 32;
  localparam int AW    = 5;
  localparam int LW    = 3;

  typedef struct packed {
    logic              sel;
    logic [5:0]        st;
    logic [3:0][WW-1:0] line;
  } item_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [2:0]         req_valid = '0;
  logic [2:0]         req_valid_d0 = '0;
  logic [2:0][AW-1:0] req_addr = '0;
  logic [2:0][WW-1:0] req_data = '0;
  logic [LW-1:0]      dbg_line = '0;
  logic [2:0][1:0]    rsp, rsp_d0;
  logic [3:0][WW-1:0] dbg_words, dbg_words_d0;

  int vectors = 0;
  int miscompares = 0;
  int cur_line = 0;
  bit done = 1'b0;
  logic [WW-1:0] sh [2][LINES][4];
  item_t q[$];
  string tags[$];

  always #4 clk = ~clk;

  lock_arb_store #(.LINES(LINES), .WORD_W(WW), .DELAY(3)) u_lock_arb_store (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .rsp(rsp), .dbg_line(dbg_line), .dbg_words(dbg_words));

  lock_arb_store #(.LINES(LINES), .WORD_W(WW), .DELAY(0)) u_lock_arb_store_d0 (
    .clk(clk), .rst(rst), .req_valid(req_valid_d0), .req_addr(req_addr),
    .req_data(req_data), .rsp(rsp_d0), .dbg_line(dbg_line), .dbg_words(dbg_words_d0));

  // monitor: compare one expected item after every edge
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      string tg;
      logic [5:0] act_st;
      logic [3:0][WW-1:0] act_ln;
      it = q.pop_front();
      tg = tags.pop_front();
      act_st = it.sel ? rsp_d0 : rsp;
      act_ln = it.sel ? dbg_words_d0 : dbg_words;
      vectors++;
      if (act_st !== it.st) begin
        miscompares++;
        $display("FAIL %s rsp actual=%h expected=%h", tg, act_st, it.st);
      end
      if (act_ln !== it.line) begin
        miscompares++;
        $display("FAIL %s line actual=%h expected=%h", tg, act_ln, it.line);
      end
    end
  end

  task automatic set_port(input int p, input logic [AW-1:0] a, input logic [WW-1:0] d);
    req_addr[p] = a;
    req_data[p] = d;
  endtask

  // driver: apply one request cycle and queue what it must produce
  task automatic step(input bit sel, input logic [2:0] v,
                      input logic [1:0] e2, input logic [1:0] e1, input logic [1:0] e0,
                      input int wr, input string tag);
    item_t it;
    @(negedge clk);
    if (sel) begin req_valid_d0 = v; req_valid = '0; end
    else     begin req_valid = v; req_valid_d0 = '0; end
    dbg_line = LW'(cur_line);
    it.sel = sel;
    it.st  = {e2, e1, e0};
    for (int w = 0; w < 4; w++) it.line[w] = sh[sel][cur_line][w];
    q.push_back(it);
    tags.push_back(tag);
    if (wr >= 0) sh[sel][req_addr[wr][4:2]][req_addr[wr][1:0]] = req_data[wr];
  endtask

  localparam logic [1:0] N = 2'd0, W = 2'd1, K = 2'd2;  // R9 codes

  initial begin
    #(8 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < LINES; l++)
        for (int w = 0; w < 4; w++) sh[s][l][w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state on both instances
    cur_line = 0;
    step(0, 3'b000, N, N, N, -1, "R1");
    step(1, 3'b000, N, N, N, -1, "R1");

    // R3 R4 R2: single client, delay 3
    set_port(0, 5'd0, 32'h1122_3344);
    step(0, 3'b001, N, N, W, -1, "R3");
    step(0, 3'b001, N, N, W, -1, "R4");
    step(0, 3'b001, N, N, W, -1, "R4");
    step(0, 3'b001, N, N, K, 0, "R3");
    step(0, 3'b000, N, N, N, -1, "R2");

    // R5 R7: staggered conflict on line 1
    cur_line = 1;
    set_port(0, 5'd5, 32'hA0A0_0001);
    set_port(1, 5'd6, 32'hB0B0_0002);
    step(0, 3'b001, N, N, W, -1, "R3");
    step(0, 3'b011, N, W, W, -1, "R5");
    step(0, 3'b011, N, W, W, -1, "R5");
    step(0, 3'b011, N, W, K, 0, "R7");
    step(0, 3'b010, N, W, N, -1, "R7");
    step(0, 3'b010, N, W, N, -1, "R7");
    step(0, 3'b010, N, W, N, -1, "R7");
    step(0, 3'b010, N, K, N, 1, "R7");
    step(0, 3'b000, N, N, N, -1, "R2");

    // R6: all three together on line 2
    cur_line = 2;
    set_port(0, 5'd8,  32'hC000_0000);
    set_port(1, 5'd9,  32'hC000_0001);
    set_port(2, 5'd10, 32'hC000_0002);
    step(0, 3'b111, W, W, W, -1, "R6");
    step(0, 3'b111, W, W, W, -1, "R6");
    step(0, 3'b111, W, W, W, -1, "R6");
    step(0, 3'b111, W, W, K, 0, "R6");
    step(0, 3'b110, W, W, N, -1, "R6");
    step(0, 3'b110, W, W, N, -1, "R6");
    step(0, 3'b110, W, W, N, -1, "R6");
    step(0, 3'b110, W, K, N, 1, "R6");
    step(0, 3'b100, W, N, N, -1, "R6");
    step(0, 3'b100, W, N, N, -1, "R6");
    step(0, 3'b100, W, N, N, -1, "R6");
    step(0, 3'b100, K, N, N, 2, "R6");
    step(0, 3'b000, N, N, N, -1, "R2");

    // R8 R5: owner pauses, intruder must not write or steal countdown
    cur_line = 3;
    set_port(2, 5'd15, 32'hD00D_0003);
    set_port(1, 5'd12, 32'hBAD0_BAD0);
    step(0, 3'b100, W, N, N, -1, "R8");
    step(0, 3'b100, W, N, N, -1, "R8");
    step(0, 3'b000, N, N, N, -1, "R8");
    step(0, 3'b010, N, W, N, -1, "R5");
    step(0, 3'b100, W, N, N, -1, "R8");
    step(0, 3'b100, K, N, N, 2, "R8");
    step(0, 3'b000, N, N, N, -1, "R5");

    // R10 R7: zero-delay instance
    cur_line = 0;
    set_port(1, 5'd2, 32'h0000_C0DE);
    set_port(0, 5'd3, 32'h0000_F00D);
    step(1, 3'b010, N, K, N, 1, "R10");
    step(1, 3'b011, N, W, K, 0, "R7");
    step(1, 3'b010, N, K, N, 1, "R10");
    step(1, 3'b000, N, N, N, -1, "R2");

    @(negedge clk);
    req_valid_d0 = '0;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule